// File: doc/BRIEF.md
# DMA Request Ordering Engine

This block sits between a device's DMA request source and the transmit side of a link. Read and write requests enter through a valid/ready port. Each request carries an address, a tag and one ordering flag. On a read the flag means *acquire*. On a write it means *release*. The block keeps up to eight requests in an age-ordered window. On each cycle it offers the oldest request whose ordering rules are satisfied. Interrupt messages are sent as ordinary posted writes, so they obey the same write ordering as data and control-update writes.

Reads that have been issued stay outstanding until a completion with the same tag comes back. Completions may arrive in any order. Each one is looked up by its tag and handed back to the requester one cycle later. A completion whose tag matches no outstanding read is dropped and reported with a single-cycle error pulse.

The rules are deliberately asymmetric:
- Plain reads may reorder freely.
- A read never passes an older write to the same 64-byte line.
- An acquire read holds back every later read until its own completion has returned.
- A release write waits until every older request has left the window and no read is outstanding.

Top module: `dmaord_engine`

## Requirements
- R1: After reset, `reqReady` is 1 and `txValid`, `rspValid` and `cplErr` are all 0.
- R2: `reqReady` is 0 whenever eight requests are pending in the window.
- R3: Writes, interrupt writes included, are issued in the order they were accepted.
- R4: A read is not issued while an older write whose address has the same bits [31:6] (the same 64-byte line) is still pending in the window.
- R5: A plain read that is eligible is issued ahead of older pending entries that are blocked. Among the eligible entries, the oldest one is always offered.
- R6: While an issued acquire read (`reqFlag`=1 with `reqIsWrite`=0) has no completion back, no read is issued. Likewise, no read is issued while an older acquire read is still pending.
- R7: A release write (`reqFlag`=1 with `reqIsWrite`=1) is issued only when no older entry is pending and no issued read is still awaiting its completion.
- R8: A completion whose tag matches an outstanding read appears on `rspValid`/`rspTag`/`rspData` on the next cycle and retires that tag. Completions may come back in any order.
- R9: A completion whose tag matches no outstanding read produces a one-cycle `cplErr` pulse on the next cycle and no response.
- R10: A plain write is issued ahead of older pending reads that are blocked, provided no older write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Window has room |
| reqIsWrite | input | 1 | 1 = posted write, 0 = read |
| reqFlag | input | 1 | Acquire on a read, release on a write |
| reqAddr | input | 32 | Byte address |
| reqTag | input | 3 | Read tag |
| txValid | output | 1 | A request is offered to the link |
| txReady | input | 1 | Link takes the offered request |
| txIsWrite | output | 1 | Type of the offered request |
| txFlag | output | 1 | Flag of the offered request |
| txAddr | output | 32 | Address of the offered request |
| txTag | output | 3 | Tag of the offered request |
| cplValid | input | 1 | Read completion arrives |
| cplTag | input | 3 | Completion tag |
| cplData | input | 32 | Completion data |
| rspValid | output | 1 | Completion returned to requester |
| rspTag | output | 3 | Tag of returned completion |
| rspData | output | 32 | Data of returned completion |
| cplErr | output | 1 | Unmatched completion pulse |

## Verification
The hardest situation to reach is a window in which every pending entry is blocked at once, each for a different reason. In that state:
- a release write waits on an outstanding read;
- a read sits behind that write on the same line;
- a third read overtakes both.

The stimulus gets there by first issuing a plain read and leaving its completion unanswered. While the link is stalled it then loads the release write, the same-line read and an unrelated read. It next returns completions one at a time and shows that nothing drains until the last outstanding read has retired.

// File: rtl/dmaord_pkg.sv
package dmaord_pkg;
  localparam int ADDR_W    = 32;
  localparam int TAG_W     = 3;
  localparam int DATA_W    = 32;
  localparam int WIN_DEPTH = 8;
  localparam int IDX_W     = $clog2(WIN_DEPTH);
  localparam int NTAG      = 1 << TAG_W;

  typedef struct packed {
    logic              isWrite;
    logic              flag;
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag;
  } req_t;

  // control -> datapath strobes
  typedef struct packed {
    logic             push;
    logic             pop;
    logic [IDX_W-1:0] sel;
    logic             cplHit;
    logic             cplMiss;
  } strobe_t;
endpackage

// File: rtl/dmaord_dp.sv
module dmaord_dp
  import dmaord_pkg::*;
#(
  parameter int LINE_LSB = 6
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  strobe_t                              stb,
  input  req_t                                 reqIn,
  input  logic [TAG_W-1:0]                     cplTag,
  input  logic [DATA_W-1:0]                    cplData,
  output logic [WIN_DEPTH-1:0]                 qValid,
  output logic [WIN_DEPTH-1:0]                 qIsW,
  output logic [WIN_DEPTH-1:0]                 qFlag,
  output logic [WIN_DEPTH-1:0][ADDR_W-LINE_LSB-1:0] qLine,
  output logic [NTAG-1:0]                      outValid,
  output logic [NTAG-1:0]                      outAcq,
  output req_t                                 txReq,
  output logic                                 rspValid,
  output logic [TAG_W-1:0]                     rspTag,
  output logic [DATA_W-1:0]                    rspData,
  output logic                                 cplErr
);
  req_t                 q  [WIN_DEPTH];
  req_t                 nq [WIN_DEPTH];
  logic [WIN_DEPTH-1:0] nv;

  // Collapsing window: slot 0 holds the oldest entry.
  always_comb begin
    logic placed;
    for (int i = 0; i < WIN_DEPTH; i++) nq[i] = q[i];
    nv = qValid;
    if (stb.pop) begin
      for (int i = 0; i < WIN_DEPTH - 1; i++) begin
        if (i >= int'(stb.sel)) begin
          nq[i] = q[i+1];
          nv[i] = qValid[i+1];
        end
      end
      nv[WIN_DEPTH-1] = 1'b0;
    end
    placed = 1'b0;
    if (stb.push) begin
      for (int i = 0; i < WIN_DEPTH; i++) begin
        if (!nv[i] && !placed) begin
          nq[i]  = reqIn;
          nv[i]  = 1'b1;
          placed = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) qValid <= '0;
    else       qValid <= nv;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WIN_DEPTH; i++) q[i] <= nq[i];
  end

  generate
    for (genvar g = 0; g < WIN_DEPTH; g++) begin : g_view
      assign qIsW[g]  = q[g].isWrite;
      assign qFlag[g] = q[g].flag;
      assign qLine[g] = q[g].addr[ADDR_W-1:LINE_LSB];
    end
  endgenerate

  assign txReq = q[stb.sel];

  // Outstanding-read table, indexed by tag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= '0;
      outAcq   <= '0;
    end else begin
      if (stb.pop && !txReq.isWrite) begin
        outValid[txReq.tag] <= 1'b1;
        outAcq[txReq.tag]   <= txReq.flag;
      end
      if (stb.cplHit) outValid[cplTag] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspTag   <= '0;
      rspData  <= '0;
      cplErr   <= 1'b0;
    end else begin
      rspValid <= stb.cplHit;
      rspTag   <= cplTag;
      rspData  <= cplData;
      cplErr   <= stb.cplMiss;
    end
  end
endmodule

// File: rtl/dmaord_ctl.sv
module dmaord_ctl
  import dmaord_pkg::*;
#(
  parameter int LINE_LSB = 6
) (
  input  logic [WIN_DEPTH-1:0]                 qValid,
  input  logic [WIN_DEPTH-1:0]                 qIsW,
  input  logic [WIN_DEPTH-1:0]                 qFlag,
  input  logic [WIN_DEPTH-1:0][ADDR_W-LINE_LSB-1:0] qLine,
  input  logic [NTAG-1:0]                      outValid,
  input  logic [NTAG-1:0]                      outAcq,
  input  logic                                 reqValid,
  input  logic                                 txReady,
  input  logic                                 cplValid,
  input  logic [TAG_W-1:0]                     cplTag,
  output strobe_t                              stb,
  output logic                                 reqReady,
  output logic                                 txValid
);
  logic [WIN_DEPTH-1:0] elig;
  logic                 readOut;
  logic                 acqOut;
  logic [IDX_W-1:0]     pick;

  assign readOut = |outValid;
  assign acqOut  = |(outValid & outAcq);

  always_comb begin
    for (int i = 0; i < WIN_DEPTH; i++) begin
      logic olderAny, olderW, olderAcq, lineHit;
      olderAny = 1'b0; olderW = 1'b0; olderAcq = 1'b0; lineHit = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (qValid[j]) begin
          olderAny = 1'b1;
          if (qIsW[j]) begin
            olderW = 1'b1;
            if (qLine[j] == qLine[i]) lineHit = 1'b1;
          end else if (qFlag[j]) begin
            olderAcq = 1'b1;
          end
        end
      end
      if (qIsW[i])
        elig[i] = qValid[i] && (qFlag[i] ? (!olderAny && !readOut) : !olderW);
      else
        elig[i] = qValid[i] && !lineHit && !olderAcq && !acqOut;
    end
  end

  // oldest eligible wins
  always_comb begin
    pick = '0;
    for (int i = WIN_DEPTH - 1; i >= 0; i--)
      if (elig[i]) pick = IDX_W'(i);
  end

  assign txValid     = |elig;
  assign reqReady    = !qValid[WIN_DEPTH-1];
  assign stb.push    = reqValid && reqReady;
  assign stb.pop     = txValid && txReady;
  assign stb.sel     = pick;
  assign stb.cplHit  = cplValid && outValid[cplTag];
  assign stb.cplMiss = cplValid && !outValid[cplTag];
endmodule

// File: rtl/dmaord_engine.sv
module dmaord_engine
  import dmaord_pkg::*;
#(
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqIsWrite,
  input  logic              reqFlag,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              txValid,
  input  logic              txReady,
  output logic              txIsWrite,
  output logic              txFlag,
  output logic [ADDR_W-1:0] txAddr,
  output logic [TAG_W-1:0]  txTag,
  input  logic              cplValid,
  input  logic [TAG_W-1:0]  cplTag,
  input  logic [DATA_W-1:0] cplData,
  output logic              rspValid,
  output logic [TAG_W-1:0]  rspTag,
  output logic [DATA_W-1:0] rspData,
  output logic              cplErr
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int LINE_W   = ADDR_W - LINE_LSB;

  strobe_t                          stb;
  req_t                             reqIn;
  req_t                             txReq;
  logic [WIN_DEPTH-1:0]             qValid, qIsW, qFlag;
  logic [WIN_DEPTH-1:0][LINE_W-1:0] qLine;
  logic [NTAG-1:0]                  outValid, outAcq;

  assign reqIn = '{isWrite: reqIsWrite, flag: reqFlag, addr: reqAddr, tag: reqTag};

  dmaord_ctl #(.LINE_LSB(LINE_LSB)) u_ctl (
    .qValid(qValid), .qIsW(qIsW), .qFlag(qFlag), .qLine(qLine),
    .outValid(outValid), .outAcq(outAcq),
    .reqValid(reqValid), .txReady(txReady),
    .cplValid(cplValid), .cplTag(cplTag),
    .stb(stb), .reqReady(reqReady), .txValid(txValid)
  );

  dmaord_dp #(.LINE_LSB(LINE_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqIn(reqIn),
    .cplTag(cplTag), .cplData(cplData),
    .qValid(qValid), .qIsW(qIsW), .qFlag(qFlag), .qLine(qLine),
    .outValid(outValid), .outAcq(outAcq), .txReq(txReq),
    .rspValid(rspValid), .rspTag(rspTag), .rspData(rspData), .cplErr(cplErr)
  );

  assign txIsWrite = txReq.isWrite;
  assign txFlag    = txReq.flag;
  assign txAddr    = txReq.addr;
  assign txTag     = txReq.tag;
endmodule

// File: rtl/dmaord_chk.sv
module dmaord_chk
  import dmaord_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic txValid,
  input logic txReady,
  input logic cplValid,
  input logic rspValid,
  input logic cplErr
);
  logic [IDX_W:0] occ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else occ <= occ + (IDX_W+1)'(reqValid && reqReady) - (IDX_W+1)'(txValid && txReady);
  end

  p_full_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (occ == (IDX_W+1)'(WIN_DEPTH)) |-> !reqReady);

  p_empty_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0) |-> !txValid);

  p_rsp_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> $past(cplValid));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cplErr) |-> $past(cplValid));

  p_err_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && cplErr));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    occ <= (IDX_W+1)'(WIN_DEPTH));
endmodule

bind dmaord_engine dmaord_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .txValid(txValid), .txReady(txReady), .cplValid(cplValid),
  .rspValid(rspValid), .cplErr(cplErr)
);

// File: tb/dmaord_engine_bench.sv
`timescale 1ns/1ps
module dmaord_engine_bench;
  localparam int OP_PUSH = 0, OP_TX = 1, OP_HIT = 2, OP_MISS = 3, OP_NOTX = 4;

  typedef struct packed {
    logic [2:0]  op;
    logic        isW;
    logic        flag;
    logic [31:0] addr;
    logic [2:0]  tag;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    // R3: writes, last one an interrupt write, in order
    '{3'd0, 1'b1, 1'b0, 32'h100,  3'd0, 32'h0},
    '{3'd0, 1'b1, 1'b0, 32'h200,  3'd0, 32'h0},
    '{3'd0, 1'b1, 1'b0, 32'h300,  3'd0, 32'h0},
    '{3'd1, 1'b1, 1'b0, 32'h100,  3'd0, 32'h0},
    '{3'd1, 1'b1, 1'b0, 32'h200,  3'd0, 32'h0},
    '{3'd1, 1'b1, 1'b0, 32'h300,  3'd0, 32'h0},
    '{3'd4, 1'b0, 1'b0, 32'h0,    3'd0, 32'h0},
    // R6 acquire, R10 write passes blocked read, R9 stray tag
    '{3'd0, 1'b0, 1'b1, 32'h1000, 3'd0, 32'h0},
    '{3'd0, 1'b0, 1'b0, 32'h2000, 3'd1, 32'h0},
    '{3'd0, 1'b1, 1'b0, 32'h3000, 3'd0, 32'h0},
    '{3'd1, 1'b0, 1'b1, 32'h1000, 3'd0, 32'h0},
    '{3'd1, 1'b1, 1'b0, 32'h3000, 3'd0, 32'h0},
    '{3'd4, 1'b0, 1'b0, 32'h0,    3'd0, 32'h0},
    '{3'd3, 1'b0, 1'b0, 32'h0,    3'd5, 32'h0},
    '{3'd2, 1'b0, 1'b0, 32'h0,    3'd0, 32'hA0},
    '{3'd1, 1'b0, 1'b0, 32'h2000, 3'd1, 32'h0},
    '{3'd2, 1'b0, 1'b0, 32'h0,    3'd1, 32'hA1},
    // R4 line hazard, R5 overtake, R7 release barrier
    '{3'd0, 1'b0, 1'b0, 32'h5000, 3'd1, 32'h0},
    '{3'd1, 1'b0, 1'b0, 32'h5000, 3'd1, 32'h0},
    '{3'd0, 1'b1, 1'b1, 32'h40,   3'd0, 32'h0},
    '{3'd0, 1'b0, 1'b0, 32'h44,   3'd2, 32'h0},
    '{3'd0, 1'b0, 1'b0, 32'h9000, 3'd3, 32'h0},
    '{3'd1, 1'b0, 1'b0, 32'h9000, 3'd3, 32'h0},
    '{3'd2, 1'b0, 1'b0, 32'h0,    3'd1, 32'hC1},
    '{3'd4, 1'b0, 1'b0, 32'h0,    3'd0, 32'h0},
    '{3'd2, 1'b0, 1'b0, 32'h0,    3'd3, 32'hC3},
    '{3'd1, 1'b1, 1'b1, 32'h40,   3'd0, 32'h0},
    '{3'd1, 1'b0, 1'b0, 32'h44,   3'd2, 32'h0},
    '{3'd2, 1'b0, 1'b0, 32'h0,    3'd2, 32'hC2},
    // R8 completions out of order, then R9 repeat tag
    '{3'd0, 1'b0, 1'b0, 32'h6000, 3'd4, 32'h0},
    '{3'd0, 1'b0, 1'b0, 32'h7000, 3'd5, 32'h0},
    '{3'd1, 1'b0, 1'b0, 32'h6000, 3'd4, 32'h0},
    '{3'd1, 1'b0, 1'b0, 32'h7000, 3'd5, 32'h0},
    '{3'd2, 1'b0, 1'b0, 32'h0,    3'd5, 32'hB5},
    '{3'd2, 1'b0, 1'b0, 32'h0,    3'd4, 32'hB4},
    '{3'd3, 1'b0, 1'b0, 32'h0,    3'd4, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqIsWrite = 1'b0, reqFlag = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqTag = '0;
  logic        txReady = 1'b0;
  logic        cplValid = 1'b0;
  logic [2:0]  cplTag = '0;
  logic [31:0] cplData = '0;
  logic        reqReady, txValid, txIsWrite, txFlag, rspValid, cplErr;
  logic [31:0] txAddr, rspData;
  logic [2:0]  txTag, rspTag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  dmaord_engine u_dmaord_engine (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsWrite(reqIsWrite), .reqFlag(reqFlag), .reqAddr(reqAddr), .reqTag(reqTag),
    .txValid(txValid), .txReady(txReady), .txIsWrite(txIsWrite), .txFlag(txFlag),
    .txAddr(txAddr), .txTag(txTag), .cplValid(cplValid), .cplTag(cplTag),
    .cplData(cplData), .rspValid(rspValid), .rspTag(rspTag), .rspData(rspData),
    .cplErr(cplErr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic w, input logic f, input logic [31:0] a, input logic [2:0] t);
    @(negedge clk);
    reqValid = 1'b1; reqIsWrite = w; reqFlag = f; reqAddr = a; reqTag = t;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectTx(input logic w, input logic f, input logic [31:0] a, input logic [2:0] t);
    @(negedge clk);
    #1;
    check("R3 R4 R5 R6 R7 R10 tx offer", {63'd0, txValid}, 64'd1);
    check("R3 R4 R5 R6 R7 R10 tx entry", {26'd0, txIsWrite, txFlag, txAddr, txTag},
          {26'd0, w, f, a, t});
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic cpl(input logic [2:0] t, input logic [31:0] d, input logic hit);
    @(negedge clk);
    cplValid = 1'b1; cplTag = t; cplData = d;
    @(negedge clk);
    cplValid = 1'b0;
    check("R8 R9 rsp/err", {61'd0, rspValid, cplErr, 1'b0}, {61'd0, hit, !hit, 1'b0});
    if (hit) check("R8 rsp tag/data", {29'd0, rspTag, rspData}, {29'd0, t, d});
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {60'd0, reqReady, txValid, rspValid, cplErr}, {60'd0, 4'b1000});
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {60'd0, reqReady, txValid, rspValid, cplErr}, {60'd0, 4'b1000});

    for (int k = 0; k < NV; k++) begin
      case (int'(VEC[k].op))
        OP_PUSH: push(VEC[k].isW, VEC[k].flag, VEC[k].addr, VEC[k].tag);
        OP_TX:   expectTx(VEC[k].isW, VEC[k].flag, VEC[k].addr, VEC[k].tag);
        OP_HIT:  cpl(VEC[k].tag, VEC[k].data, 1'b1);
        OP_MISS: cpl(VEC[k].tag, VEC[k].data, 1'b0);
        default: begin
          @(negedge clk); #1;
          check("R6 R7 blocked window", {63'd0, txValid}, 64'd0);
        end
      endcase
    end

    // R2: fill the window while the link is stalled
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      check("R2 room before fill", {63'd0, reqReady}, 64'd1);
      push(1'b1, 1'b0, 32'h8000 + i * 32'h40, 3'd0);
    end
    @(negedge clk); #1;
    check("R2 full window", {63'd0, reqReady}, 64'd0);
    // extra request while full must not enter
    push(1'b1, 1'b0, 32'hDEAD0000, 3'd0);
    // R3: drain in acceptance order, then nothing is left
    for (int i = 0; i < 8; i++) expectTx(1'b1, 1'b0, 32'h8000 + i * 32'h40, 3'd0);
    @(negedge clk); #1;
    check("R2 rejected request absent", {63'd0, txValid}, 64'd0);

    done = 1;
    finishRun();
  end
endmodule